// File: doc/BRIEF.md
# NAND Host Command Sequencer

This block is the host side of a byte-wide NAND flash bus. A request port takes an operation code, a 19-bit byte address and, for programs, a byte count. From these it produces chip enable, the command and address latch strobes, the write strobe and the I/O byte stream, in the order each operation needs. Program data is pulled one byte at a time from a data input through a take pulse.

Program and erase end with a confirm opcode. After the confirm byte, the sequencer watches the ready/busy line. It waits for the line to go busy and then ready, and only then reports completion. A timeout flags a flash that never becomes ready. A new request is refused while a sequence or a busy wait is running. The one exception is reset, which is taken at any time and replaces the running work.

Top module: `nand_cmd_sequencer`

## Requirements
- R1: Every byte is sent with `nandCeN` low. `nandWeN` goes low and then high, and `nandIo`, `nandCle` and `nandAle` stay stable while `nandWeN` is low, so the byte is latched by the rising edge.
- R2: Opcode bytes have `nandCle`=1 and `nandAle`=0. Address bytes have `nandAle`=1 and `nandCle`=0. Data bytes have both at 0. The two are never 1 together.
- R3: A read (reqOp=0) sends 00h, then the address bytes A[7:0], A[15:8] and {5'b0, A[18:16]}, in that order.
- R4: A program (reqOp=1) sends 80h, the three address bytes of R3, then reqLen data bytes, then 10h. Each data byte is the `wrData` value present in the cycle where `wrDataTake` is high, and the bytes go out in the order they were taken.
- R5: An erase (reqOp=2) sends 60h, then A[15:8], then {5'b0, A[18:16]}, then D0h.
- R6: Status read (reqOp=3) sends only 70h. ID read (reqOp=4) sends only 90h. Reset (reqOp=5) sends only FFh. `doneOut` pulses after the byte.
- R7: The write strobe stays low for max(strobeClks, 2) clocks. It stays high for at least that many clocks before the next low phase.
- R8: After a program or erase confirm, `doneOut` pulses only after `nandRb` has gone low (busy) and then high (ready). `errOut` stays 0 in that case.
- R9: If the busy wait lasts TIMEOUT_CLKS clocks without ready, `doneOut` pulses together with `errOut`=1.
- R10: `reqReady` is 0 from acceptance until `doneOut`. Non-reset requests made while it is 0 are ignored. Op codes 6 and 7 are ignored even when the block is idle.
- R11: Reset (reqOp=5) is accepted in any state. It abandons the running sequence or busy wait and sends FFh. Only the reset's `doneOut` follows.
- R12: `nandCeN` is high after reset and from the `doneOut` pulse onward, until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqOp | input | 3 | Operation code: 0 read, 1 program, 2 erase, 3 status, 4 ID, 5 reset |
| reqAddr | input | 19 | Byte address |
| reqLen | input | 9 | Program data byte count |
| strobeClks | input | 4 | Write strobe half width in clocks, minimum 2 applied; sampled on acceptance |
| reqReady | output | 1 | High when a new request will be taken |
| wrData | input | 8 | Program data byte |
| wrDataTake | output | 1 | The data byte on `wrData` is taken in this cycle |
| doneOut | output | 1 | One-cycle completion pulse |
| errOut | output | 1 | Busy-wait timeout, valid with `doneOut` |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch strobe |
| nandAle | output | 1 | Address latch strobe |
| nandWeN | output | 1 | Write strobe, active low |
| nandIo | output | 8 | Bus byte |
| nandRb | input | 1 | Ready/busy from the flash, 1 = ready |

## Verification
Each operation is run with seeded random addresses, data counts from zero upward, and strobe settings below, at and above the minimum. A bus monitor records each latched byte with its latch strobes. This separates wrong opcode or confirm choice, wrong address byte order, and miscounted data bytes. Directed cases each isolate one behaviour:
- a long busy period, which exposes completion before ready;
- a flash that never becomes ready in time, which exposes the timeout;
- a read request during a busy wait, which exposes a refusal leak;
- a reset issued in the middle of a wait, which exposes abort handling;
- an illegal op code, which exposes a phantom sequence.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_STATUS = 3'd3,
    OP_ID     = 3'd4,
    OP_RESET  = 3'd5
  } opcode_e;

  typedef enum logic [1:0] {
    BK_CMD1,
    BK_ADDR,
    BK_DATA,
    BK_CMD2
  } byteKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      latchReq;   // capture request, take bus, start guard high phase
    logic      sendByte;   // drive next byte and start a write pulse
    byteKind_e kind;
    logic [1:0] addrIdx;
    opcode_e   op;
    logic      releaseCe;
  } dpCtl_t;

  function automatic logic [7:0] leadCode(opcode_e op);
    case (op)
      OP_READ:   return 8'h00;
      OP_PROG:   return 8'h80;
      OP_ERASE:  return 8'h60;
      OP_STATUS: return 8'h70;
      OP_ID:     return 8'h90;
      default:   return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] confirmCode(opcode_e op);
    case (op)
      OP_PROG:  return 8'h10;
      OP_ERASE: return 8'hD0;
      default:  return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int STRB_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        wrData,
  input  logic [STRB_W-1:0] strobeClks,
  input  logic              nandRb,
  output logic              byteDone,
  output logic              rbReady,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic [7:0]        nandIo
);

  localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
  localparam int PAD_W      = 8 * ADDR_BYTES;
  localparam logic [STRB_W-1:0] MIN_HALF = STRB_W'(2);

  logic [PAD_W-1:0]  addrReg;
  logic [STRB_W-1:0] halfReg;
  logic [STRB_W-1:0] cnt;
  logic              active;
  logic              lowPhase;
  logic [1:0]        rbPipe;
  logic [7:0]        nextByte;

  always_comb begin
    case (ctl.kind)
      BK_CMD1: nextByte = leadCode(ctl.op);
      BK_CMD2: nextByte = confirmCode(ctl.op);
      BK_DATA: nextByte = wrData;
      default: nextByte = addrReg[ctl.addrIdx*8 +: 8];
    endcase
  end

  assign byteDone = active && !lowPhase && (cnt == halfReg - 1'b1);
  assign rbReady  = rbPipe[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rbPipe <= 2'b11;
    end else begin
      rbPipe <= {rbPipe[0], nandRb};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      halfReg  <= MIN_HALF;
      cnt      <= '0;
      active   <= 1'b0;
      lowPhase <= 1'b0;
      nandCeN  <= 1'b1;
      nandCle  <= 1'b0;
      nandAle  <= 1'b0;
      nandWeN  <= 1'b1;
      nandIo   <= '0;
    end else if (ctl.latchReq) begin
      addrReg  <= PAD_W'(reqAddr);
      halfReg  <= (strobeClks < MIN_HALF) ? MIN_HALF : strobeClks;
      nandCeN  <= 1'b0;
      nandCle  <= 1'b0;
      nandAle  <= 1'b0;
      nandWeN  <= 1'b1;
      active   <= 1'b1;
      lowPhase <= 1'b0;
      cnt      <= '0;
    end else if (ctl.sendByte) begin
      nandIo   <= nextByte;
      nandCle  <= (ctl.kind == BK_CMD1) || (ctl.kind == BK_CMD2);
      nandAle  <= (ctl.kind == BK_ADDR);
      nandWeN  <= 1'b0;
      active   <= 1'b1;
      lowPhase <= 1'b1;
      cnt      <= '0;
    end else if (ctl.releaseCe) begin
      nandCeN  <= 1'b1;
      nandCle  <= 1'b0;
      nandAle  <= 1'b0;
    end else if (active) begin
      if (cnt == halfReg - 1'b1) begin
        cnt <= '0;
        if (lowPhase) begin
          lowPhase <= 1'b0;
          nandWeN  <= 1'b1;
        end else begin
          active <= 1'b0;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle)); // R2

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstN)
    !nandWeN |-> !nandCeN); // R1

  AST_BUS_STABLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN && $past(!nandWeN)) |-> $stable({nandCle, nandAle, nandIo})); // R1

  AST_LOW_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(nandWeN) && !ctl.latchReq) |=> !nandWeN); // R7

  AST_HIGH_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |=> nandWeN); // R7

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int LEN_W        = 9,
  parameter int TIMEOUT_CLKS = 4096,
  parameter int ADDR_BYTES   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       reqOp,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             byteDone,
  input  logic             rbReady,
  output dpCtl_t           ctl,
  output logic             reqReady,
  output logic             wrDataTake,
  output logic             doneOut,
  output logic             errOut
);

  localparam int TMO_W = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [1:0] LAST_IDX  = 2'(ADDR_BYTES - 1);
  localparam logic [1:0] ROW_FIRST = 2'(ADDR_BYTES - 2);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CLKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_GUARD, S_SEND, S_WAITBSY, S_WAITRDY} state_e;

  state_e           state;
  opcode_e          opReg;
  logic [LEN_W-1:0] lenLeft;
  byteKind_e        phase;
  logic [1:0]       addrIdx;
  logic [TMO_W-1:0] waitCnt;

  logic      accept, advance, waiting, readySeen, timeoutHit, finishing;
  byteKind_e nextKind;
  logic [1:0] nextIdx;
  logic      stepByte, stepFinish, stepWait;

  assign reqReady  = (state == S_IDLE);
  assign accept    = reqValid && ((reqOp == 3'(OP_RESET)) ||
                                  (reqReady && reqOp <= 3'(OP_RESET)));
  assign advance   = (state == S_SEND) && byteDone && !accept;
  assign waiting   = (state == S_WAITBSY) || (state == S_WAITRDY);
  assign readySeen = (state == S_WAITRDY) && rbReady;
  assign timeoutHit = waiting && !readySeen && (waitCnt == TMO_LAST);
  assign finishing = !accept && ((advance && stepFinish) || readySeen || timeoutHit);

  // choose the byte that follows the current one
  always_comb begin
    nextKind   = phase;
    nextIdx    = addrIdx;
    stepByte   = 1'b0;
    stepFinish = 1'b0;
    stepWait   = 1'b0;
    case (phase)
      BK_CMD1: begin
        if (opReg == OP_READ || opReg == OP_PROG) begin
          nextKind = BK_ADDR; nextIdx = '0; stepByte = 1'b1;
        end else if (opReg == OP_ERASE) begin
          nextKind = BK_ADDR; nextIdx = ROW_FIRST; stepByte = 1'b1;
        end else begin
          stepFinish = 1'b1;
        end
      end
      BK_ADDR: begin
        if (addrIdx != LAST_IDX) begin
          nextIdx = addrIdx + 1'b1; stepByte = 1'b1;
        end else if (opReg == OP_PROG) begin
          nextKind = (lenLeft != '0) ? BK_DATA : BK_CMD2; stepByte = 1'b1;
        end else if (opReg == OP_ERASE) begin
          nextKind = BK_CMD2; stepByte = 1'b1;
        end else begin
          stepFinish = 1'b1;
        end
      end
      BK_DATA: begin
        nextKind = (lenLeft != '0) ? BK_DATA : BK_CMD2; stepByte = 1'b1;
      end
      default: stepWait = 1'b1;
    endcase
  end

  always_comb begin
    ctl           = '0;
    ctl.op        = opReg;
    ctl.latchReq  = accept;
    ctl.sendByte  = !accept && (((state == S_GUARD) && byteDone) || (advance && stepByte));
    ctl.kind      = (state == S_GUARD) ? BK_CMD1 : nextKind;
    ctl.addrIdx   = (state == S_GUARD) ? 2'd0 : nextIdx;
    ctl.releaseCe = finishing;
  end

  assign wrDataTake = ctl.sendByte && (ctl.kind == BK_DATA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opReg   <= OP_READ;
      lenLeft <= '0;
      phase   <= BK_CMD1;
      addrIdx <= '0;
      waitCnt <= '0;
      doneOut <= 1'b0;
      errOut  <= 1'b0;
    end else begin
      doneOut <= finishing;
      errOut  <= finishing && timeoutHit;
      if (accept) begin
        state   <= S_GUARD;
        opReg   <= opcode_e'(reqOp);
        lenLeft <= reqLen;
        phase   <= BK_CMD1;
        addrIdx <= '0;
      end else if (ctl.sendByte) begin
        state   <= S_SEND;
        phase   <= ctl.kind;
        addrIdx <= ctl.addrIdx;
        if (ctl.kind == BK_DATA) lenLeft <= lenLeft - 1'b1;
      end else if (finishing) begin
        state <= S_IDLE;
      end else if (advance && stepWait) begin
        state   <= S_WAITBSY;
        waitCnt <= '0;
      end else if (waiting) begin
        waitCnt <= waitCnt + 1'b1;
        if (state == S_WAITBSY && !rbReady) state <= S_WAITRDY;
      end
    end
  end

  AST_TAKE_ONLY_PROG: assert property (@(posedge clk) disable iff (!rstN)
    wrDataTake |-> (opReg == OP_PROG)); // R4

  AST_REFUSE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady && reqOp != 3'(OP_RESET)) |=> $stable(opReg)); // R10

endmodule

// File: rtl/nand_cmd_sequencer.sv
module nand_cmd_sequencer
  import nand_seq_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int LEN_W        = 9,
  parameter int STRB_W       = 4,
  parameter int TIMEOUT_CLKS = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [STRB_W-1:0] strobeClks,
  output logic              reqReady,
  input  logic [7:0]        wrData,
  output logic              wrDataTake,
  output logic              doneOut,
  output logic              errOut,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic [7:0]        nandIo,
  input  logic              nandRb
);

  localparam int ADDR_BYTES = (ADDR_W + 7) / 8;

  dpCtl_t ctl;
  logic   byteDone;
  logic   rbReady;

  nand_seq_ctrl #(
    .LEN_W(LEN_W), .TIMEOUT_CLKS(TIMEOUT_CLKS), .ADDR_BYTES(ADDR_BYTES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqLen(reqLen),
    .byteDone(byteDone), .rbReady(rbReady), .ctl(ctl), .reqReady(reqReady),
    .wrDataTake(wrDataTake), .doneOut(doneOut), .errOut(errOut)
  );

  nand_seq_dp #(
    .ADDR_W(ADDR_W), .STRB_W(STRB_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .wrData(wrData),
    .strobeClks(strobeClks), .nandRb(nandRb), .byteDone(byteDone), .rbReady(rbReady),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandIo(nandIo)
  );

  AST_CE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> nandCeN); // R12

endmodule

// File: tb/nand_cmd_sequencer_tb_top.sv
`timescale 1ns/1ps
module nand_cmd_sequencer_tb_top;

  localparam int TMO = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqOp = '0;
  logic [18:0] reqAddr = '0;
  logic [8:0] reqLen = '0;
  logic [3:0] strobeClks = 4'd2;
  logic reqReady, wrDataTake, doneOut, errOut;
  logic nandCeN, nandCle, nandAle, nandWeN;
  logic [7:0] nandIo, wrData;
  logic nandRb = 1'b1;

  always #2.5 clk = ~clk;

  nand_cmd_sequencer #(.TIMEOUT_CLKS(TMO)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqLen(reqLen), .strobeClks(strobeClks), .reqReady(reqReady), .wrData(wrData),
    .wrDataTake(wrDataTake), .doneOut(doneOut), .errOut(errOut), .nandCeN(nandCeN),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandIo(nandIo),
    .nandRb(nandRb)
  );

  int nChk = 0;
  int nFail = 0;
  logic [7:0] progData [0:15];
  int dataIdx = 0;
  logic [9:0] mon [0:1023];
  int monN = 0;
  logic [9:0] expv [0:63];
  int expN = 0;
  int expHalf = 2;
  int lowRun = 0;
  int busyFalls = 0;
  int busyLen = 10;
  event kickEv;

  assign wrData = progData[dataIdx % 16];

  always @(posedge clk) if (wrDataTake) dataIdx <= dataIdx + 1;

  // bus monitor: a byte counts when the write strobe rises with chip enable low (R1)
  always @(posedge nandWeN) begin
    if (rstN && !nandCeN) begin
      mon[monN % 1024] = {nandCle, nandAle, nandIo};
      monN++;
      if (nandCle && (nandIo == 8'h10 || nandIo == 8'hD0)) -> kickEv;
    end
  end

  // flash ready/busy model
  always begin
    @(kickEv);
    repeat (3) @(posedge clk);
    nandRb <= 1'b0;
    repeat (busyLen) @(posedge clk);
    nandRb <= 1'b1;
  end

  always @(negedge clk) begin
    if (rstN && !nandWeN) lowRun++;
    else if (lowRun != 0) begin
      chk(lowRun == expHalf, "R7 low width", lowRun, expHalf);
      lowRun = 0;
    end
  end

  always @(negedge nandRb) busyFalls++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] v);
    expv[expN] = v;
    expN++;
  endtask

  task automatic buildExp(input int op, input logic [18:0] a, input int len, input int base);
    expN = 0;
    case (op)
      0: begin push({2'b10, 8'h00}); push({2'b01, a[7:0]}); push({2'b01, a[15:8]});
               push({2'b01, 5'b0, a[18:16]}); end
      1: begin push({2'b10, 8'h80}); push({2'b01, a[7:0]}); push({2'b01, a[15:8]});
               push({2'b01, 5'b0, a[18:16]});
               for (int i = 0; i < len; i++) push({2'b00, progData[(base + i) % 16]});
               push({2'b10, 8'h10}); end
      2: begin push({2'b10, 8'h60}); push({2'b01, a[15:8]}); push({2'b01, 5'b0, a[18:16]});
               push({2'b10, 8'hD0}); end
      3: push({2'b10, 8'h70});
      4: push({2'b10, 8'h90});
      default: push({2'b10, 8'hFF});
    endcase
  endtask

  task automatic issue(input int op, input logic [18:0] a, input int len, input int strb);
    @(negedge clk);
    reqOp = 3'(op); reqAddr = a; reqLen = 9'(len); strobeClks = 4'(strb);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(output bit err);
    do @(negedge clk); while (!doneOut);
    err = errOut;
  endtask

  task automatic compareLog(input int base, input string req);
    chk(monN - base == expN, req, monN - base, expN);
    for (int i = 0; i < expN; i++)
      chk(mon[(base + i) % 1024] == expv[i], req, int'(mon[(base + i) % 1024]), int'(expv[i]));
  endtask

  task automatic runOp(input int op, input logic [18:0] a, input int len, input int strb,
                       input int bl, input string req);
    int mb, db, bf;
    bit err;
    busyLen = bl;
    mb = monN; db = dataIdx; bf = busyFalls;
    buildExp(op, a, len, db);
    expHalf = (strb < 2) ? 2 : strb;
    issue(op, a, len, strb);
    chk(reqReady == 1'b0, "R10 not ready while running", int'(reqReady), 0);
    waitDone(err);
    compareLog(mb, req);
    chk(err == 1'b0, "R8 no error", int'(err), 0);
    if (op == 1 || op == 2) begin
      chk(busyFalls == bf + 1, "R8 busy seen before done", busyFalls - bf, 1);
      chk(nandRb == 1'b1, "R8 ready at done", int'(nandRb), 1);
    end
    if (op == 1) chk(dataIdx - db == len, "R4 data take count", dataIdx - db, len);
    chk(nandCeN == 1'b1, "R12 CE released at done", int'(nandCeN), 1);
    @(negedge clk);
    chk(reqReady == 1'b1, "R10 ready after done", int'(reqReady), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    int mb, bf;
    bit err;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) progData[i] = 8'(i * 37 + 5);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(nandCeN == 1'b1, "R12 reset CE", int'(nandCeN), 1);
    chk(nandWeN == 1'b1, "R1 reset WE", int'(nandWeN), 1);
    chk(reqReady == 1'b1, "R10 reset ready", int'(reqReady), 1);
    chk(doneOut == 1'b0, "R6 reset done", int'(doneOut), 0);

    // directed operations
    runOp(0, 19'h5A3C7, 0, 0, 0, "R3 R1 R2 read");
    runOp(1, 19'h7FFFF, 3, 1, 12, "R4 R2 program");
    runOp(1, 19'h00000, 0, 2, 8, "R4 program no data");
    runOp(2, 19'h4B2E1, 0, 5, 20, "R5 erase");
    runOp(3, 19'h0, 0, 3, 0, "R6 status");
    runOp(4, 19'h0, 0, 2, 0, "R6 id");
    runOp(5, 19'h0, 0, 4, 0, "R6 R11 reset idle");

    // illegal op code leaves the bus alone
    mb = monN;
    issue(6, 19'h12345, 0, 2);
    repeat (30) @(negedge clk);
    chk(monN == mb, "R10 illegal op no bytes", monN - mb, 0);
    chk(nandCeN == 1'b1, "R10 illegal op CE high", int'(nandCeN), 1);
    chk(reqReady == 1'b1, "R10 illegal op ready", int'(reqReady), 1);

    // timeout
    busyLen = TMO + 100;
    mb = monN;
    expHalf = 2;
    issue(1, 19'h01234, 1, 2);
    waitDone(err);
    chk(err == 1'b1, "R9 timeout error", int'(err), 1);
    chk(nandCeN == 1'b1, "R9 R12 CE after timeout", int'(nandCeN), 1);
    wait (nandRb == 1'b1);
    repeat (4) @(negedge clk);

    // refused read and reset abort during busy wait
    busyLen = 200;
    mb = monN; bf = dataIdx;
    buildExp(2, 19'h6DD11, 0, bf);
    push({2'b10, 8'hFF});
    expHalf = 3;
    issue(2, 19'h6DD11, 0, 3);
    do @(negedge clk); while (nandRb == 1'b1);
    repeat (5) @(negedge clk);
    chk(reqReady == 1'b0, "R10 refused during busy", int'(reqReady), 0);
    issue(0, 19'h11111, 0, 3);
    repeat (20) @(negedge clk);
    chk(monN - mb == 4, "R10 no read bytes during busy", monN - mb, 4);
    issue(5, 19'h0, 0, 3);
    waitDone(err);
    compareLog(mb, "R11 abort wait with reset");
    chk(err == 1'b0, "R11 reset no error", int'(err), 0);
    wait (nandRb == 1'b1);
    repeat (4) @(negedge clk);

    // seeded random mix
    for (int k = 0; k < 25; k++) begin
      int op, len, strb, bl;
      logic [18:0] a;
      op   = int'($urandom % 5);
      a    = 19'($urandom);
      len  = int'($urandom % 6);
      strb = int'($urandom % 5);
      bl   = 5 + int'($urandom % 20);
      runOp(op, a, len, strb, bl, "R3 R4 R5 R6 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule